// File: doc/BRIEF.md
# Shared-cache set replacement controller with per-core insertion points

This block keeps the replacement order of one set in a shared, many-way last-level cache that several cores use at once. The order is a priority stack of ways running from the least recently used end (position 1) to the most recently used end (position W). Each stack slot holds a way index and the ID of the core that brought that block in. The tag and data arrays live elsewhere. This block only decides which way leaves on a miss and how the order changes on each access.

On a miss the way at the LRU end is reported as the victim. The same way is then reused for the incoming block. That block goes in at the position given by the requesting core's allocation register. Entries below that position move one place toward LRU. Entries above it stay where they are.

On a hit the block is not moved straight to MRU. It swaps places with its MRU-side neighbour, whichever core owns that neighbour, and only when a free-running pseudo-random value falls below a programmable threshold. Over time each core's share of the set tends toward its allocation without any strict partition. The allocations are expected to add up to W. Software or a utility monitor loads them between accesses.

Top module: `ppr_set_repl`

## Requirements
- R1: After reset, stack slot s (slot 0 = position 1 = LRU end, slot W-1 = MRU end) holds way s with owner 0, and every core's allocation register holds W/CORES.
- R2: `victim_way_o` always shows the way in slot 0. On a miss, that way index is the one written into the new entry.
- R3: A miss (`access_i`=1, `hit_i`=0) from core c with allocation k changes the stack one clock edge later. Slots 0..k-2 take the old contents of slots 1..k-1. Slot k-1 gets {old slot 0 way, owner c}. Slots k..W-1 do not change.
- R4: An allocation value of 0 inserts at position 1. A value greater than W inserts at position W.
- R5: A promoted hit on the way in slot s (s < W-1) swaps slots s and s+1. Each way moves together with its owner field, and the owner of the hit block does not change.
- R6: A hit is promoted when the free-running LFSR value is below `prob_thr_i`. A threshold of all ones always promotes. A threshold of zero never promotes and leaves the stack unchanged.
- R7: A hit on the way already in slot W-1 leaves the stack unchanged.
- R8: While `access_i` is 0 the stack does not change, whatever the other inputs do.
- R9: `alloc_we_i` writes `alloc_val_i` into the register of core `alloc_core_i` only when `access_i` is 0. When `access_i` is 1 the write is ignored.
- R10: The stack always holds each way index exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| access_i | input | 1 | One access to this set in this cycle |
| hit_i | input | 1 | Access hit (1) or missed (0) |
| hit_way_i | input | $clog2(WAYS) | Way that hit |
| core_i | input | $clog2(CORES) | Requesting core |
| alloc_we_i | input | 1 | Allocation register write strobe |
| alloc_core_i | input | $clog2(CORES) | Core whose allocation is written |
| alloc_val_i | input | $clog2(WAYS)+1 | New allocation value |
| prob_thr_i | input | PROB_W | Promotion threshold; all ones means always |
| victim_way_o | output | $clog2(WAYS) | Way at the LRU end (victim on a miss) |
| stack_way_o | output | WAYS*$clog2(WAYS) | Way of slot s at bits [s*$clog2(WAYS) +: $clog2(WAYS)] |
| stack_owner_o | output | WAYS*$clog2(CORES) | Owner of slot s at bits [s*$clog2(CORES) +: $clog2(CORES)] |

## Verification
The embedded properties assume that a hit names a way that is resident in the set. That always holds while the stack stays a permutation. They also assume that WAYS and CORES are powers of two, so that every index value selects a real slot or core. The stimulus draws every hit way from the bench's own model of the stack and uses an 8-way, 2-core configuration. It drives promotion only with thresholds of zero or all ones, so that every expected order is exact. Allocation values go past W and down to zero only in the clamp scenario, and one write is deliberately made during an access to show that it is ignored.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_MISS    = 2'd1,
    OP_PROMOTE = 2'd2
  } ppr_op_e;

  // Right-shift Galois feedback masks, maximal length, widths 4..16
  function automatic logic [15:0] lfsr_mask(input int unsigned width);
    case (width)
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0829;
      13:      return 16'h100D;
      14:      return 16'h2015;
      15:      return 16'h6000;
      16:      return 16'hD008;
      default: return 16'h00B8;
    endcase
  endfunction

endpackage

// File: rtl/ppr_lfsr.sv
module ppr_lfsr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] value_o
);
  localparam logic [15:0]  FULL_MASK = ppr_pkg::lfsr_mask(W);
  localparam logic [W-1:0] MASK      = FULL_MASK[W-1:0];

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= W'(1);
    else if (q[0]) q <= (q >> 1) ^ MASK;
    else q <= q >> 1;
  end

  assign value_o = q;

  // R6: a stuck-at-zero sequence would silently stop all promotions
  a_r6_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni) q != '0);

endmodule

// File: rtl/ppr_stack.sv
module ppr_stack #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned CORES  = 4,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned CORE_W = $clog2(CORES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  ppr_pkg::ppr_op_e                  op_i,
  input  logic [WAY_W-1:0]                  ins_slot_i,
  input  logic [CORE_W-1:0]                 core_i,
  input  logic [WAY_W-1:0]                  hit_way_i,
  output logic                              hit_at_mru_o,
  output logic [WAYS-1:0][WAY_W-1:0]        way_o,
  output logic [WAYS-1:0][CORE_W-1:0]       own_o
);
  import ppr_pkg::*;

  logic [WAYS-1:0][WAY_W-1:0]  way_q, way_d, way_up, way_dn;
  logic [WAYS-1:0][CORE_W-1:0] own_q, own_d, own_up, own_dn;
  logic [WAY_W-1:0]            hit_slot;
  logic                        at_mru;

  // Neighbour views: up = contents one slot nearer MRU, dn = one nearer LRU
  assign way_up = {way_q[0], way_q[WAYS-1:1]};
  assign own_up = {own_q[0], own_q[WAYS-1:1]};
  assign way_dn = {way_q[WAYS-2:0], way_q[WAYS-1]};
  assign own_dn = {own_q[WAYS-2:0], own_q[WAYS-1]};

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (way_q[i] == hit_way_i) hit_slot = WAY_W'(i);
    end
  end

  assign at_mru       = (hit_slot == WAY_W'(WAYS - 1));
  assign hit_at_mru_o = at_mru;

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      way_d[i] = way_q[i];
      own_d[i] = own_q[i];
      if (op_i == OP_MISS) begin
        if (WAY_W'(i) < ins_slot_i) begin
          way_d[i] = way_up[i];
          own_d[i] = own_up[i];
        end else if (WAY_W'(i) == ins_slot_i) begin
          way_d[i] = way_q[0];
          own_d[i] = core_i;
        end
      end else if (op_i == OP_PROMOTE && !at_mru) begin
        if (WAY_W'(i) == hit_slot) begin
          way_d[i] = way_up[i];
          own_d[i] = own_up[i];
        end else if (WAY_W'(i) == hit_slot + WAY_W'(1)) begin
          way_d[i] = way_dn[i];
          own_d[i] = own_dn[i];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WAYS; i++) begin
        way_q[i] <= WAY_W'(i);
        own_q[i] <= '0;
      end
    end else begin
      way_q <= way_d;
      own_q <= own_d;
    end
  end

  assign way_o = way_q;
  assign own_o = own_q;

  logic [WAYS-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < WAYS; i++) present[way_q[i]] = 1'b1;
  end

  // R10
  a_r10_way_permutation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(present) == WAYS);

  // R2, R3: the evicted way reappears at the insertion slot with the new owner
  a_r2_victim_reused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_MISS |=> way_q[$past(ins_slot_i)] == $past(way_q[0]) &&
                        own_q[$past(ins_slot_i)] == $past(core_i));

  // R5
  a_r5_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PROMOTE && !at_mru) |=> way_q[$past(hit_slot) + WAY_W'(1)] == $past(hit_way_i));

  // R7
  a_r7_mru_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PROMOTE && at_mru) |=> $stable(way_q) && $stable(own_q));

  // R8
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_IDLE |=> $stable(way_q) && $stable(own_q));

endmodule

// File: rtl/ppr_set_repl.sv
module ppr_set_repl #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned CORES  = 4,
  parameter int unsigned PROB_W = 8,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned CORE_W = $clog2(CORES),
  localparam int unsigned AL_W   = WAY_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      access_i,
  input  logic                      hit_i,
  input  logic [WAY_W-1:0]          hit_way_i,
  input  logic [CORE_W-1:0]         core_i,
  input  logic                      alloc_we_i,
  input  logic [CORE_W-1:0]         alloc_core_i,
  input  logic [AL_W-1:0]           alloc_val_i,
  input  logic [PROB_W-1:0]         prob_thr_i,
  output logic [WAY_W-1:0]          victim_way_o,
  output logic [WAYS*WAY_W-1:0]     stack_way_o,
  output logic [WAYS*CORE_W-1:0]    stack_owner_o
);
  import ppr_pkg::*;

  logic [AL_W-1:0]             alloc_q [CORES];
  logic [AL_W-1:0]             req_alloc, ins_pos, pos_m1;
  logic [WAY_W-1:0]            ins_slot;
  logic [PROB_W-1:0]           rnd;
  logic                        promote_ok, hit_at_mru;
  ppr_op_e                     op;
  logic [WAYS-1:0][WAY_W-1:0]  way_v;
  logic [WAYS-1:0][CORE_W-1:0] own_v;

  for (genvar c = 0; c < CORES; c++) begin : g_alloc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alloc_q[c] <= AL_W'(WAYS / CORES);
      else if (alloc_we_i && !access_i && alloc_core_i == CORE_W'(c)) alloc_q[c] <= alloc_val_i;
    end

    // R9
    a_r9_alloc_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      access_i |=> alloc_q[c] == $past(alloc_q[c]));
  end

  // Clamp the allocation into the legal insertion range 1..WAYS
  assign req_alloc = alloc_q[core_i];
  always_comb begin
    if (req_alloc == '0)                ins_pos = AL_W'(1);
    else if (req_alloc > AL_W'(WAYS))  ins_pos = AL_W'(WAYS);
    else                               ins_pos = req_alloc;
  end
  assign pos_m1   = ins_pos - AL_W'(1);
  assign ins_slot = pos_m1[WAY_W-1:0];

  ppr_lfsr #(.W(PROB_W)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .value_o (rnd)
  );

  assign promote_ok = (&prob_thr_i) || (rnd < prob_thr_i);

  always_comb begin
    op = OP_IDLE;
    if (access_i) begin
      if (!hit_i)          op = OP_MISS;
      else if (promote_ok) op = OP_PROMOTE;
    end
  end

  ppr_stack #(.WAYS(WAYS), .CORES(CORES)) i_stack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op),
    .ins_slot_i   (ins_slot),
    .core_i       (core_i),
    .hit_way_i    (hit_way_i),
    .hit_at_mru_o (hit_at_mru),
    .way_o        (way_v),
    .own_o        (own_v)
  );

  assign victim_way_o  = way_v[0];
  assign stack_way_o   = way_v;
  assign stack_owner_o = own_v;

  // R6: a zero threshold must never reorder on a hit
  a_r6_zero_thr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && hit_i && prob_thr_i == '0) |=> $stable(stack_way_o));

  // R4: a clamped miss never lands outside the stack
  a_r4_insert_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !hit_i && (req_alloc == '0)) |=> stack_way_o[WAY_W-1:0] == $past(victim_way_o));

  // R7 at the ports
  a_r7_mru_hit_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && hit_i && hit_at_mru) |=> $stable(stack_owner_o));

endmodule

// File: tb/test_ppr_set_repl.sv
module test_ppr_set_repl;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 8;
  localparam int CORES = 2;
  localparam int PROB_W = 8;
  localparam int WAY_W = 3;
  localparam int CORE_W = 1;
  localparam int AL_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic access_i = 0, hit_i = 0, alloc_we_i = 0;
  logic [WAY_W-1:0] hit_way_i = '0;
  logic [CORE_W-1:0] core_i = '0, alloc_core_i = '0;
  logic [AL_W-1:0] alloc_val_i = '0;
  logic [PROB_W-1:0] prob_thr_i = '0;
  logic [WAY_W-1:0] victim_way_o;
  logic [WAYS*WAY_W-1:0] stack_way_o;
  logic [WAYS*CORE_W-1:0] stack_owner_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [WAY_W-1:0] m_way [WAYS];
  logic [CORE_W-1:0] m_own [WAYS];
  int m_alloc [CORES];

  always #(CLK_PERIOD/2) clk = ~clk;

  ppr_set_repl #(.WAYS(WAYS), .CORES(CORES), .PROB_W(PROB_W)) i_ppr_set_repl (
    .clk_i(clk), .rst_ni(rst_ni), .access_i(access_i), .hit_i(hit_i),
    .hit_way_i(hit_way_i), .core_i(core_i), .alloc_we_i(alloc_we_i),
    .alloc_core_i(alloc_core_i), .alloc_val_i(alloc_val_i), .prob_thr_i(prob_thr_i),
    .victim_way_o(victim_way_o), .stack_way_o(stack_way_o), .stack_owner_o(stack_owner_o)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WAYS*WAY_W-1:0] exp_ways();
    logic [WAYS*WAY_W-1:0] v;
    for (int s = 0; s < WAYS; s++) v[s*WAY_W +: WAY_W] = m_way[s];
    return v;
  endfunction

  function automatic logic [WAYS*CORE_W-1:0] exp_owns();
    logic [WAYS*CORE_W-1:0] v;
    for (int s = 0; s < WAYS; s++) v[s*CORE_W +: CORE_W] = m_own[s];
    return v;
  endfunction

  task automatic chk_stack(string req, string what);
    chk(req, {what, " ways"}, 64'(stack_way_o), 64'(exp_ways()));
    chk(req, {what, " owners"}, 64'(stack_owner_o), 64'(exp_owns()));
  endtask

  function automatic void model_miss(int core);
    int pos;
    logic [WAY_W-1:0] v;
    pos = (m_alloc[core] == 0) ? 1 : (m_alloc[core] > WAYS) ? WAYS : m_alloc[core];
    v = m_way[0];
    for (int i = 0; i < pos - 1; i++) begin
      m_way[i] = m_way[i+1];
      m_own[i] = m_own[i+1];
    end
    m_way[pos-1] = v;
    m_own[pos-1] = CORE_W'(core);
  endfunction

  function automatic void model_hit(logic [WAY_W-1:0] way, bit prom);
    int s = 0;
    logic [WAY_W-1:0] tw;
    logic [CORE_W-1:0] to;
    for (int i = 0; i < WAYS; i++) if (m_way[i] == way) s = i;
    if (prom && s < WAYS - 1) begin
      tw = m_way[s]; m_way[s] = m_way[s+1]; m_way[s+1] = tw;
      to = m_own[s]; m_own[s] = m_own[s+1]; m_own[s+1] = to;
    end
  endfunction

  // Called at a negedge; returns at the next negedge with the update visible
  task automatic do_miss(int core, string req);
    chk("R2", "victim before miss", 64'(victim_way_o), 64'(m_way[0]));
    access_i = 1; hit_i = 0; core_i = CORE_W'(core);
    @(negedge clk);
    access_i = 0;
    model_miss(core);
    chk_stack(req, "after miss");
  endtask

  task automatic do_hit(logic [WAY_W-1:0] way, bit prom, string req);
    access_i = 1; hit_i = 1; hit_way_i = way;
    @(negedge clk);
    access_i = 0; hit_i = 0;
    model_hit(way, prom);
    chk_stack(req, "after hit");
  endtask

  task automatic write_alloc(int core, int val);
    alloc_we_i = 1; alloc_core_i = CORE_W'(core); alloc_val_i = AL_W'(val);
    @(negedge clk);
    alloc_we_i = 0;
    m_alloc[core] = val;
  endtask

  task automatic t_reset();
    for (int s = 0; s < WAYS; s++) begin m_way[s] = WAY_W'(s); m_own[s] = '0; end
    for (int c = 0; c < CORES; c++) m_alloc[c] = WAYS / CORES;
    chk_stack("R1", "reset");
    chk("R1", "reset victim", 64'(victim_way_o), 64'd0);
    do_miss(1, "R1");  // default allocation W/CORES = 4
  endtask

  task automatic t_quota_example();
    write_alloc(0, 5);
    write_alloc(1, 3);
    do_miss(1, "R3");
    do_miss(0, "R3");
    do_miss(0, "R3");
    do_miss(1, "R3");
    do_miss(1, "R9");
  endtask

  task automatic t_promote_always();
    prob_thr_i = '1;
    do_hit(m_way[2], 1, "R5");
    do_hit(m_way[0], 1, "R6");
    do_hit(m_way[4], 1, "R5");
  endtask

  task automatic t_promote_never();
    prob_thr_i = '0;
    do_hit(m_way[1], 0, "R6");
    do_hit(m_way[5], 0, "R6");
  endtask

  task automatic t_hit_mru();
    prob_thr_i = '1;
    do_hit(m_way[WAYS-1], 0, "R7");
  endtask

  task automatic t_idle();
    hit_i = 1; hit_way_i = m_way[0]; core_i = 1; prob_thr_i = '1;
    repeat (4) @(negedge clk);
    hit_i = 0;
    chk_stack("R8", "idle");
  endtask

  task automatic t_clamp();
    write_alloc(0, 0);
    do_miss(0, "R4");
    write_alloc(1, 15);
    do_miss(1, "R4");
  endtask

  task automatic t_locked();
    // write during a miss must be ignored; the miss itself uses 15 -> W
    alloc_we_i = 1; alloc_core_i = 1; alloc_val_i = AL_W'(1);
    chk("R2", "victim before locked miss", 64'(victim_way_o), 64'(m_way[0]));
    access_i = 1; hit_i = 0; core_i = 1;
    @(negedge clk);
    access_i = 0; alloc_we_i = 0;
    model_miss(1);
    chk_stack("R9", "miss with write");
    do_miss(1, "R9");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_quota_example();
    t_promote_always();
    t_promote_never();
    t_hit_mru();
    t_idle();
    t_clamp();
    t_locked();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule